// File: doc/BRIEF.md
# Zero-Packed Rational Resampling Load Scheduler

This block sequences the data loads and coefficient choices for a five-path polyphase channelizer. The channelizer changes the sample rate by a rational factor whose up-sampling part is two. No zero samples are ever stored. Each implied zero becomes a skipped register row: every accepted input sample is written two rows below the previous one, taken modulo five. Samples are grouped into two alternating load states. At the end of each state one output is due, and the block presents, for each of the five rows, which of ten half-density coefficient subsets that row must use.

Two ratios are available. With a factor of 5/2, the load states take three and then two samples. With a factor of 15/2, they take eight and then seven. The ratio select is a static setting and may only change while reset is held. The block also has a purely combinational permutation. The transform that follows the polyphase filter delivers its channels in stride-two order, and the permutation puts them back into natural order. The filter arithmetic and the transform itself belong to other blocks.

Top module: `zp_resamp_sched`

## Requirements
- R1: While reset is asserted and right after it is released, `wr_row` is 4, the load state is the first one, and the coefficient base is 0. The first `blk_done` after reset therefore shows the subsets 0,6,2,8,4 for rows 0 to 4.
- R2: Each cycle with `smp_valid` high moves `wr_row` to (`wr_row` + 3) mod 5, which is a step of -2 mod 5. This also holds across load-state boundaries. A cycle without `smp_valid` leaves `wr_row` unchanged.
- R3: With `ratio_sel` = 0 (ratio 5/2), the first load state takes 3 samples and the second takes 2. `blk_done` is high on the 3rd and 5th sample of every 5-sample period and on no other sample.
- R4: With `ratio_sel` = 1 (ratio 15/2), the first load state takes 8 samples and the second takes 7. `blk_done` is high on the 8th and 15th sample of every 15-sample period.
- R5: While `blk_done` is high, field r of `coef_sel` (bits 4r+3:4r) equals (base + 6·r) mod 10, where base is the current coefficient base.
- R6: The coefficient base starts at 0 and advances by 5 mod 10 after each `blk_done`, so it alternates 0, 5, 0, 5 and so on.
- R7: `wr_en` follows `smp_valid` in the same cycle. `blk_done` is never high in a cycle without a sample.
- R8: Slot j of `dft_in` (bits j·DW +: DW) carries channel (2·j) mod 5. Field c of `chan_out` carries channel c, taken from slot (3·c) mod 5, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 1 | 0 selects 5/2, 1 selects 15/2; change only during reset |
| smp_valid | input | 1 | An input sample is present this cycle |
| wr_en | output | 1 | Write strobe for the data register bank |
| wr_row | output | 3 | Row (0..4) that receives the current sample |
| blk_done | output | 1 | The current sample closes a load state; an output is due |
| coef_sel | output | 20 | Five 4-bit coefficient-subset indices, row r in bits 4r+3:4r |
| dft_in | input | 5*DW | Transform outputs in stride-two channel order |
| chan_out | output | 5*DW | Channel outputs in natural order |

## Verification
The bench builds the block with DW = 16. This width is wide enough to tag every transform slot with a distinct channel marker, so any wrong slot-to-channel mapping shows up in the permutation check. Each ratio is run for at least four full address periods, with idle gaps mixed in. This covers both state lengths, the state wrap, the base alternation, and the wrap of the row address across a state boundary. A reset between the two ratio runs confirms that the schedule starts again from row 4 and base 0.

// File: rtl/zp_resamp_sched.sv
module zp_resamp_sched #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ratio_sel,
  input  logic            smp_valid,
  output logic            wr_en,
  output logic [2:0]      wr_row,
  output logic            blk_done,
  output logic [19:0]     coef_sel,
  input  logic [5*DW-1:0] dft_in,
  output logic [5*DW-1:0] chan_out
);
  localparam int NP = 5;
  localparam int NS = 10;
  localparam int CW = 4;
  localparam int ROW_STEP = 2;
  localparam int SUB_ROW = 6;
  localparam int SUB_STATE = NS / 2;

  logic [2:0]    row_q;
  logic [2:0]    cnt_q;
  logic          st_q;
  logic [CW-1:0] base_q;
  logic [2:0]    last_idx;

  assign last_idx = ratio_sel ? (st_q ? 3'd6 : 3'd7) : (st_q ? 3'd1 : 3'd2);
  assign wr_en    = smp_valid;
  assign wr_row   = row_q;
  assign blk_done = smp_valid && (cnt_q == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= 3'd4;
      cnt_q  <= '0;
      st_q   <= 1'b0;
      base_q <= '0;
    end else if (smp_valid) begin
      row_q <= (row_q >= 3'(ROW_STEP)) ? row_q - 3'(ROW_STEP) : row_q + 3'(NP - ROW_STEP);
      if (cnt_q == last_idx) begin
        cnt_q  <= '0;
        st_q   <= ~st_q;
        base_q <= (base_q >= CW'(SUB_STATE)) ? base_q - CW'(SUB_STATE) : base_q + CW'(SUB_STATE);
      end else begin
        cnt_q <= cnt_q + 3'd1;
      end
    end
  end

  for (genvar r = 0; r < NP; r++) begin : g_coef
    localparam int OFS = (SUB_ROW * r) % NS;
    logic [CW:0] sum;
    assign sum = {1'b0, base_q} + (CW+1)'(OFS);
    assign coef_sel[r*CW +: CW] = (sum >= (CW+1)'(NS)) ? CW'(sum - (CW+1)'(NS)) : CW'(sum);
  end

  for (genvar c = 0; c < NP; c++) begin : g_reorder
    localparam int SLOT = (3 * c) % NP;
    assign chan_out[c*DW +: DW] = dft_in[SLOT*DW +: DW];
  end

  a_r1_reset_start: assert property (@(posedge clk)
    $rose(rst_n) |-> (wr_row == 3'd4 && base_q == '0 && !st_q));

  a_r2_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (wr_row == 3'((int'($past(wr_row)) + 3) % 5)));

  a_r2_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(wr_row));

  a_r7_done_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> wr_en);

  a_r6_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (base_q == CW'((int'($past(base_q)) + 5) % 10)));

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= last_idx));
endmodule

// File: tb/zp_resamp_sched_tb_top.sv
module zp_resamp_sched_tb_top;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ratio_sel = 1'b0;
  logic smp_valid = 1'b0;
  logic wr_en, blk_done;
  logic [2:0] wr_row;
  logic [19:0] coef_sel;
  logic [5*DW-1:0] dft_in = '0;
  logic [5*DW-1:0] chan_out;
  int n_chk = 0;
  int n_bad = 0;
  int exp_row, exp_cnt, exp_st, exp_base;

  always #10 clk = ~clk;

  zp_resamp_sched #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .smp_valid(smp_valid),
    .wr_en(wr_en), .wr_row(wr_row), .blk_done(blk_done), .coef_sel(coef_sel),
    .dft_in(dft_in), .chan_out(chan_out));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; ratio_sel = mode;
    @(negedge clk); #1;
    chk("R1 row in reset", int'(wr_row), 4);
    chk("R1 no done in reset", int'(blk_done), 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 row after reset", int'(wr_row), 4);
    exp_row = 4; exp_cnt = 0; exp_st = 0; exp_base = 0;
  endtask

  task automatic t_schedule(input logic mode, input int nsamp);
    string rq;
    int last;
    rq = mode ? "R4" : "R3";
    for (int i = 0; i < nsamp; i++) begin
      if (i % 4 == 3) begin
        @(negedge clk); smp_valid = 1'b0; #1;
        chk("R7 no write when idle", int'(wr_en), 0);
        chk("R7 no done when idle", int'(blk_done), 0);
      end
      @(negedge clk); smp_valid = 1'b1; #1;
      last = mode ? (exp_st != 0 ? 6 : 7) : (exp_st != 0 ? 1 : 2);
      chk("R7 write strobe", int'(wr_en), 1);
      chk("R2 row address", int'(wr_row), exp_row);
      chk(rq, int'(blk_done), (exp_cnt == last) ? 1 : 0);
      if (exp_cnt == last) begin
        for (int r = 0; r < 5; r++)
          chk(exp_base == 0 ? "R5 coef (R1 base0)" : "R5 coef (R6 base5)",
              int'(coef_sel[r*4 +: 4]), (exp_base + 6*r) % 10);
        exp_cnt = 0; exp_st = 1 - exp_st; exp_base = (exp_base + 5) % 10;
      end else begin
        exp_cnt++;
      end
      exp_row = (exp_row + 3) % 5;
    end
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic t_reorder(input int seed);
    @(negedge clk);
    for (int j = 0; j < 5; j++)
      dft_in[j*DW +: DW] = DW'(seed * 16 + ((2*j) % 5));
    #1;
    for (int c = 0; c < 5; c++)
      chk("R8 channel order", int'(chan_out[c*DW +: DW]), seed * 16 + c);
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset(1'b0);
    t_schedule(1'b0, 5 * 5);
    t_reset(1'b1);
    t_schedule(1'b1, 15 * 4 + 3);
    t_reset(1'b0);
    t_schedule(1'b0, 12);
    t_reorder(1);
    t_reorder(7);
    t_reorder(200);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule